// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block drives eight edge-aligned pulse-width outputs from a single free-running up-counter. All channels share one period, set by a 16-bit modulus and a power-of-two prescaler, and each channel sets its own duty through its own compare value. The counter advances on one of three clock-enable inputs, picked by a source field. A source code of zero stops the counter.

Software reaches the block through a simple synchronous register bus. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the address. A protection latch can be armed to freeze the timing and output configuration. It can only be released through a separate unlock register. Modulus and compare writes go to holding registers. The counter picks them up at a period boundary, so a running waveform never shows a truncated or stretched period.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset the control register reads 0 (counter stopped), the modulus reads 0xFFFF, the mask reads 0xFF, polarity and the guard bit read 0, and every output is low.
- R2: The period is (MOD+1)·2^ps counter-enable ticks, where ps is control bits [2:0]. A channel with compare value C ≤ MOD is high for C·2^ps of those ticks in each period, while the counter is below C.
- R3: A compare value of 0 gives a constant low output, and a compare value greater than MOD gives a constant high output (before polarity).
- R4: A 1 in polarity register bit i (address 3) inverts output i.
- R5: A 1 in mask register bit i (address 2) holds output i at its idle level, which equals polarity bit i.
- R6: Control bits [4:3] pick the counter enable: 1 system, 2 fixed, 3 external. With 0 the counter and prescaler are held at zero.
- R7: Writing 1 to bit 0 of the guard register (address 4) arms protection, and the guard register reads the live state in bit 0. While protection is armed, writes to control, modulus, mask, polarity and compare registers are ignored.
- R8: Writing 1 to bit 0 of the unlock register (address 5) disarms protection. Address 5 reads 1 in bit 0 while writes are allowed.
- R9: New modulus and compare values take effect when the counter wraps from MOD to 0, or at once while the counter is stopped. A compare write in the wrap cycle itself applies from the following period.
- R10: The register map is: control at 0, modulus at 1 (bits [15:0]), mask at 2 and polarity at 3 (bits [7:0]), channel i compare at 8+i. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_sys_i | input | 1 | System-rate counter enable |
| tick_fix_i | input | 1 | Fixed-rate counter enable |
| tick_ext_i | input | 1 | External-rate counter enable |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 32 | Read data for addr_i |
| pwm_o | output | 8 | Channel outputs |

## Verification
A compare write and a period wrap can land on the same clock edge, and the holding-register transfer must then use the value from before the write. The bench sets the modulus to 0 with the system enable held high, so every cycle is a wrap. It then writes a new compare value and samples the channel on the next two falling edges. The first sample must still show the old duty and the second must show the new one. Duty checks elsewhere count high cycles over windows that are whole multiples of the period, so they do not depend on the counter phase.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } clk_src_e;

  localparam int A_CTRL   = 0;
  localparam int A_MOD    = 1;
  localparam int A_MASK   = 2;
  localparam int A_POL    = 3;
  localparam int A_GUARD  = 4;
  localparam int A_UNLOCK = 5;
  localparam int CMP_BASE = 8;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output clk_src_e                      src_o,
  output logic [PS_W-1:0]               ps_o,
  output logic [CNT_W-1:0]              mod_o,
  output logic [NUM_CH-1:0]             mask_o,
  output logic [NUM_CH-1:0]             pol_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_o,
  output logic                          wp_o
);
  localparam int CTRL_W = PS_W + 2;

  logic wr_ok;
  assign wr_ok = we_i && !wp_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= SRC_OFF;
      ps_o   <= '0;
      mod_o  <= '1;
      mask_o <= '1;
      pol_o  <= '0;
      cmp_o  <= '0;
      wp_o   <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_W'(A_GUARD) && wdata_i[0]) wp_o <= 1'b1;
      if (we_i && addr_i == ADDR_W'(A_UNLOCK) && wdata_i[0]) wp_o <= 1'b0;
      if (wr_ok) begin
        if (addr_i == ADDR_W'(A_CTRL)) begin
          ps_o  <= wdata_i[PS_W-1:0];
          src_o <= clk_src_e'(wdata_i[PS_W+1:PS_W]);
        end
        if (addr_i == ADDR_W'(A_MOD))  mod_o  <= wdata_i[CNT_W-1:0];
        if (addr_i == ADDR_W'(A_MASK)) mask_o <= wdata_i[NUM_CH-1:0];
        if (addr_i == ADDR_W'(A_POL))  pol_o  <= wdata_i[NUM_CH-1:0];
        for (int i = 0; i < NUM_CH; i++)
          if (addr_i == ADDR_W'(CMP_BASE + i)) cmp_o[i] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CTRL))   rdata_o[CTRL_W-1:0] = {src_o, ps_o};
    if (addr_i == ADDR_W'(A_MOD))    rdata_o[CNT_W-1:0]  = mod_o;
    if (addr_i == ADDR_W'(A_MASK))   rdata_o[NUM_CH-1:0] = mask_o;
    if (addr_i == ADDR_W'(A_POL))    rdata_o[NUM_CH-1:0] = pol_o;
    if (addr_i == ADDR_W'(A_GUARD))  rdata_o[0] = wp_o;
    if (addr_i == ADDR_W'(A_UNLOCK)) rdata_o[0] = !wp_o;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == ADDR_W'(CMP_BASE + i)) rdata_o[CNT_W-1:0] = cmp_o[i];
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_sys_i,
  input  logic             tick_fix_i,
  input  logic             tick_ext_i,
  input  clk_src_e         src_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_mod_o,
  output logic             load_o
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic             tick;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic             adv, wrap;

  always_comb begin
    case (src_i)
      SRC_SYS: tick = tick_sys_i;
      SRC_FIX: tick = tick_fix_i;
      SRC_EXT: tick = tick_ext_i;
      default: tick = 1'b0;
    endcase
  end

  assign pre_lim = (PRE_W'(1) << ps_i) - PRE_W'(1);
  assign adv     = tick && (pre_q >= pre_lim);
  assign wrap    = adv && (cnt_o == act_mod_o);
  assign load_o  = (src_i == SRC_OFF) || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      cnt_o     <= '0;
      act_mod_o <= '1;
    end else if (src_i == SRC_OFF) begin
      pre_q     <= '0;
      cnt_o     <= '0;
      act_mod_o <= mod_i;
    end else if (tick) begin
      if (adv) begin
        pre_q <= '0;
        if (wrap) begin
          cnt_o     <= '0;
          act_mod_o <= mod_i;
        end else begin
          cnt_o <= cnt_o + CNT_W'(1);
        end
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             mask_i,
  input  logic             pol_i,
  output logic [CNT_W-1:0] act_cmp_o,
  output logic             pwm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_cmp_o <= '0;
    else if (load_i) act_cmp_o <= cmp_i;
  end

  // masked channels sit at their idle level
  assign pwm_o = mask_i ? pol_i : ((cnt_i < act_cmp_o) ^ pol_i);
endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_sys_i,
  input  logic              tick_fix_i,
  input  logic              tick_ext_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  clk_src_e                     src;
  logic [PS_W-1:0]              ps;
  logic [CNT_W-1:0]             mod_q, cnt, act_mod;
  logic [NUM_CH-1:0]            mask_q, pol_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q, act_cmp;
  logic                         wp, load;

  pwm_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .src_o(src), .ps_o(ps), .mod_o(mod_q), .mask_o(mask_q), .pol_o(pol_q),
    .cmp_o(cmp_q), .wp_o(wp)
  );

  pwm_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
    .clk_i, .rst_ni, .tick_sys_i, .tick_fix_i, .tick_ext_i,
    .src_i(src), .ps_i(ps), .mod_i(mod_q),
    .cnt_o(cnt), .act_mod_o(act_mod), .load_o(load)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni, .load_i(load), .cnt_i(cnt), .cmp_i(cmp_q[i]),
      .mask_i(mask_q[i]), .pol_i(pol_q[i]),
      .act_cmp_o(act_cmp[i]), .pwm_o(pwm_o[i])
    );
  end
endmodule

// File: rtl/shared_pwm_timer_chk.sv
module shared_pwm_timer_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [1:0]                   src_i,
  input logic [CNT_W-1:0]             cnt_i,
  input logic [CNT_W-1:0]             act_mod_i,
  input logic [CNT_W-1:0]             mod_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_cmp_i,
  input logic [NUM_CH-1:0]            mask_i,
  input logic [NUM_CH-1:0]            pol_i,
  input logic [NUM_CH-1:0]            pwm_i,
  input logic                         wp_i,
  input logic                         we_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [DATA_W-1:0]            wdata_i
);
  a_r6_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i == 2'd0 |=> cnt_i == '0);

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= act_mod_i);

  a_r9_mod_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != 2'd0 && cnt_i != act_mod_i) |=> $stable(act_mod_i));

  a_r7_mod_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i && we_i && addr_i == ADDR_W'(1)) |=> $stable(mod_i));

  a_r8_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(5) && wdata_i[0]) |=> !wp_i);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    a_r5_mask_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_i[i] |-> pwm_i[i] == pol_i[i]);
    a_r3_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mask_i[i] && act_cmp_i[i] == '0) |-> pwm_i[i] == pol_i[i]);
    a_r3_over_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mask_i[i] && act_cmp_i[i] > act_mod_i) |-> pwm_i[i] != pol_i[i]);
    a_r9_cmp_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i != 2'd0 && cnt_i != act_mod_i) |=> $stable(act_cmp_i[i]));
  end
endmodule

bind shared_pwm_timer shared_pwm_timer_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i, .rst_ni, .src_i(src), .cnt_i(cnt), .act_mod_i(act_mod), .mod_i(mod_q),
  .act_cmp_i(act_cmp), .mask_i(mask_q), .pol_i(pol_q), .pwm_i(pwm_o),
  .wp_i(wp), .we_i, .addr_i, .wdata_i
);

// File: tb/sim_shared_pwm_timer.sv
`timescale 1ns/1ps
module sim_shared_pwm_timer;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tick_sys_i = 1'b1, tick_fix_i = 1'b0, tick_ext_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic [7:0]  pwm_o;

  int checks = 0, fails = 0;

  typedef struct {string tag; int ch; int win; int exp;} item_t;
  item_t q[$];

  always #2 clk_i = ~clk_i;

  shared_pwm_timer u0 (.*);

  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      tick_fix_i = ~tick_fix_i;
      tick_ext_i = (cyc % 4 == 0);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    addr_i = 4'(a); wdata_i = 32'(d); we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk_i);
    addr_i = 4'(a);
    #1 chk(tag, int'(rdata_o), exp);
  endtask

  task automatic push(input string tag, input int ch, input int win, input int exp);
    item_t it;
    it.tag = tag; it.ch = ch; it.win = win; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk_i);
  endtask

  // monitor: counts high cycles of one channel over a window
  initial begin
    forever begin
      item_t it;
      int n;
      wait (q.size() != 0);
      it = q[0];
      n = 0;
      for (int k = 0; k < it.win; k++) begin
        @(negedge clk_i);
        n += int'(pwm_o[it.ch]);
      end
      chk($sformatf("%s ch%0d", it.tag, it.ch), n, it.exp);
      q.delete(0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state, R10 map
    rd(0, 0, "R1 ctrl");
    rd(1, 'hFFFF, "R1 mod");
    rd(2, 'hFF, "R1 mask");
    rd(3, 0, "R1 pol");
    rd(4, 0, "R1 guard");
    rd(6, 0, "R10 unmapped");
    chk("R1 outputs", int'(pwm_o), 0);

    // configure while stopped (R9 transparent load)
    wr(1, 9);
    wr(8, 3); wr(9, 0); wr(10, 12); wr(11, 10); wr(12, 3); wr(14, 9);
    wr(3, 'h30); wr(2, 'h20);
    rd(10, 12, "R10 cmp2 readback");
    wr(0, 'h08);                       // src sys, ps 0
    repeat (30) @(negedge clk_i);
    push("R2 duty", 0, 20, 6);
    push("R3 zero", 1, 20, 0);
    push("R3 over", 2, 20, 20);
    push("R3 mod+1", 3, 20, 20);
    push("R4 invert", 4, 20, 14);
    push("R5 masked idle", 5, 20, 20);
    push("R2 cmp=mod", 6, 20, 18);
    drain();

    wr(0, 'h09);                       // R2 prescale /2
    repeat (50) @(negedge clk_i);
    push("R2 prescale", 0, 40, 12);
    drain();

    wr(0, 'h10);                       // R6 fixed
    repeat (50) @(negedge clk_i);
    push("R6 fixed src", 0, 40, 12);
    drain();

    wr(0, 'h18);                       // R6 external
    repeat (90) @(negedge clk_i);
    push("R6 ext src", 0, 80, 24);
    drain();

    wr(0, 'h00);                       // R6 stopped
    repeat (4) @(negedge clk_i);
    push("R6 stopped", 0, 20, 20);
    push("R6 stopped", 1, 20, 0);
    drain();

    wr(0, 'h08);
    repeat (30) @(negedge clk_i);
    wr(4, 1);                          // R7 arm
    rd(4, 1, "R7 guard reads set");
    rd(5, 0, "R8 unlock reads locked");
    wr(8, 7); wr(2, 'hFF); wr(1, 4); wr(3, 'hFF); wr(0, 0);
    rd(8, 3, "R7 cmp locked");
    rd(2, 'h20, "R7 mask locked");
    rd(1, 9, "R7 mod locked");
    rd(3, 'h30, "R7 pol locked");
    rd(0, 'h08, "R7 ctrl locked");
    repeat (30) @(negedge clk_i);
    push("R7 waveform kept", 0, 20, 6);
    drain();

    wr(5, 1);                          // R8 unlock
    rd(4, 0, "R8 guard cleared");
    wr(8, 7);
    rd(8, 7, "R8 write accepted");
    repeat (30) @(negedge clk_i);
    push("R8 new duty", 0, 20, 14);
    drain();

    // R9 compare write colliding with a wrap (MOD=0 wraps every cycle)
    wr(1, 0);
    repeat (30) @(negedge clk_i);
    chk("R9 ch7 before", int'(pwm_o[7]), 0);
    wr(15, 1);
    chk("R9 old value in wrap cycle", int'(pwm_o[7]), 0);
    @(negedge clk_i);
    chk("R9 new value next period", int'(pwm_o[7]), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule